// File: doc/BRIEF.md
# Slot-Port Network Interrupt Aggregator

This block gathers per-port network interrupt requests from seven adapter slots into two 32-bit status banks, called bank A and bank B. Every slot owns one 8-bit lane, and each bit in that lane stands for one of the slot's ports. The lanes are not laid out in slot order. Slots 0, 1, 3 and 4 share bank A, and slots 2, 5 and 6 share bank B. The lowest byte of bank B has no owner.

Interrupt sources raise and drop their bits through two separate request channels, one for setting and one for clearing. Each channel carries a strobe, a slot number and a port number. Software reads both status banks and reads or writes one 32-bit mask per bank over a simple register bus. Writes take effect at a clock edge and reads return data combinationally.

A single registered, level-sensitive interrupt line is high whenever any status bit is set together with its mask bit.

Top module: `netirq_aggregator`

## Requirements
- R1: Bank A lane placement: slot 0 uses bits 7:0, slot 1 uses bits 15:8, slot 4 uses bits 23:16 and slot 3 uses bits 31:24.
- R2: Bank B lane placement: slot 2 uses bits 15:8, slot 6 uses bits 23:16 and slot 5 uses bits 31:24. Bank B bits 7:0 always read 0.
- R3: A set strobe for (slot, port) sets the bit at lane base plus port, one clock edge later. A clear strobe for the same pair clears that bit. All other bits keep their values.
- R4: A request with slot number 7, or with a port number above 7, changes no status bit.
- R5: When a set and a clear target the same bit in one cycle, the bit ends up set. When they target different bits, both take effect.
- R6: The irq output is a register. After each clock edge it equals the OR over both banks of (status AND mask), using the status and mask values that edge produced. Request strobes and mask writes therefore show on irq at the same edge that updates the state.
- R7: Bank A status reads at byte addresses 0x10 to 0x13 and bank B status reads at 0x18 to 0x1B. Writes to these addresses change nothing.
- R8: Mask A is read and written at address 0x20 and mask B at address 0x28, as full 32-bit registers. A write to any other address changes no mask. A read of an unmapped address returns 0.
- R9: A synchronous active-high reset clears all status bits, both masks and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Set request strobe |
| set_slot | input | 3 | Slot number for the set request |
| set_port | input | 4 | Port number for the set request |
| clr_stb | input | 1 | Clear request strobe |
| clr_slot | input | 3 | Slot number for the clear request |
| clr_port | input | 4 | Port number for the clear request |
| bus_addr | input | 8 | Register bus byte address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data (combinational) |
| irq | output | 1 | Level interrupt output |

## Verification
A wrong lane position or a wrong bit in the status state shows up right away on the next status read: some bit is set at a place that no (slot, port) pair maps to, or an expected bit is missing. The bench sweeps every slot and port value, including the illegal ones, and reads both banks after each request. This catches any wrong or extra bit within one cycle of the request that caused it. An error in the masking or in the interrupt register shows on the irq pin one edge after the request or mask write that triggered it, and the bench samples irq after every such event.

// File: rtl/netirq_pkg.sv
package netirq_pkg;

    localparam int NUM_SLOTS      = 7;
    localparam int LANE_W         = 8;
    localparam int REG_W          = 32;
    localparam int NUM_BANKS      = 2;
    localparam int SLOT_W         = 3;
    localparam int PORT_W         = 4;
    localparam int ADDR_W         = 8;
    localparam int LANES_PER_BANK = REG_W / LANE_W;
    localparam int LANE_IDX_W     = $clog2(LANES_PER_BANK);
    localparam int BYTE_SEL_W     = $clog2(REG_W / 8);

    localparam logic [ADDR_W-1:0] STS_BASE   = 8'h10;
    localparam logic [ADDR_W-1:0] MSK_BASE   = 8'h20;
    localparam logic [ADDR_W-1:0] BANK_STRIDE = 8'h08;

    typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

    typedef struct packed {
        logic                  valid;
        bank_e                 bank;
        logic [LANE_IDX_W-1:0] lane;
    } lane_loc_t;

    typedef struct packed {
        logic              stb;
        logic [SLOT_W-1:0] slot;
        logic [PORT_W-1:0] port;
    } irq_req_t;

    // Fixed, non-linear slot placement shared by decode logic.
    function automatic lane_loc_t slot_to_lane(input logic [SLOT_W-1:0] slot);
        lane_loc_t loc;
        loc = '{valid: 1'b1, bank: BANK_A, lane: '0};
        case (slot)
            3'd0:    begin loc.bank = BANK_A; loc.lane = 2'd0; end
            3'd1:    begin loc.bank = BANK_A; loc.lane = 2'd1; end
            3'd2:    begin loc.bank = BANK_B; loc.lane = 2'd1; end
            3'd3:    begin loc.bank = BANK_A; loc.lane = 2'd3; end
            3'd4:    begin loc.bank = BANK_A; loc.lane = 2'd2; end
            3'd5:    begin loc.bank = BANK_B; loc.lane = 2'd3; end
            3'd6:    begin loc.bank = BANK_B; loc.lane = 2'd2; end
            default: loc.valid = 1'b0;
        endcase
        return loc;
    endfunction

    function automatic logic [ADDR_W-1:0] sts_addr(input int bank);
        return STS_BASE + ADDR_W'(bank) * BANK_STRIDE;
    endfunction

    function automatic logic [ADDR_W-1:0] msk_addr(input int bank);
        return MSK_BASE + ADDR_W'(bank) * BANK_STRIDE;
    endfunction

endpackage

// File: rtl/netirq_req_decode.sv
module netirq_req_decode
    import netirq_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  irq_req_t                            req,
    output logic [NUM_BANKS-1:0][REG_W-1:0]     hit
);

    lane_loc_t loc;
    logic      legal;

    always_comb begin
        loc   = slot_to_lane(req.slot);
        legal = req.stb && loc.valid && (req.port < PORT_W'(LANE_W));
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar i = 0; i < REG_W; i++) begin : g_bit
            assign hit[b][i] = legal
                && (loc.bank == bank_e'(b))
                && (loc.lane == LANE_IDX_W'(i / LANE_W))
                && (req.port == PORT_W'(i % LANE_W));
        end
    end

    // R3
    hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    // R4
    illegal_req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req.slot >= SLOT_W'(NUM_SLOTS) || req.port >= PORT_W'(LANE_W)) |-> (hit == '0));

endmodule

// File: rtl/netirq_status_bank.sv
module netirq_status_bank
    import netirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_hit,
    input  logic [REG_W-1:0] clr_hit,
    output logic [REG_W-1:0] sts_q,
    output logic [REG_W-1:0] sts_next
);

    // Set wins over clear on the same bit.
    always_comb sts_next = (sts_q & ~clr_hit) | set_hit;

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= sts_next;
    end

    // R3 R5
    set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_hit) |=> ((sts_q & $past(set_hit)) == $past(set_hit)));

    // R3
    clr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_hit & ~set_hit)) |=> ((sts_q & $past(clr_hit & ~set_hit)) == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_hit == '0 && clr_hit == '0) |=> $stable(sts_q));

endmodule

// File: rtl/netirq_regbus.sv
module netirq_regbus
    import netirq_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            bus_wr,
    input  logic [REG_W-1:0]                bus_wdata,
    input  logic [NUM_BANKS-1:0][REG_W-1:0] sts_q,
    output logic [NUM_BANKS-1:0][REG_W-1:0] msk_q,
    output logic [NUM_BANKS-1:0][REG_W-1:0] msk_next,
    output logic [REG_W-1:0]                bus_rdata
);

    logic [NUM_BANKS-1:0] sts_sel;
    logic [NUM_BANKS-1:0] msk_sel;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
        localparam logic [ADDR_W-1:0] S_ADDR = sts_addr(b);
        localparam logic [ADDR_W-1:0] M_ADDR = msk_addr(b);

        assign sts_sel[b] = (bus_addr[ADDR_W-1:BYTE_SEL_W] == S_ADDR[ADDR_W-1:BYTE_SEL_W]);
        assign msk_sel[b] = (bus_addr == M_ADDR);

        always_comb msk_next[b] = (bus_wr && msk_sel[b]) ? bus_wdata : msk_q[b];

        always_ff @(posedge clk) begin
            if (rst) msk_q[b] <= '0;
            else     msk_q[b] <= msk_next[b];
        end

        // R8
        mask_write_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && msk_sel[b]) |=> (msk_q[b] == $past(bus_wdata)));

        // R8
        mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(bus_wr && msk_sel[b]) |=> $stable(msk_q[b]));
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sts_sel[b]) bus_rdata = sts_q[b];
            if (msk_sel[b]) bus_rdata = msk_q[b];
        end
    end

endmodule

// File: rtl/netirq_aggregator.sv
module netirq_aggregator
    import netirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_stb,
    input  logic [SLOT_W-1:0]    set_slot,
    input  logic [PORT_W-1:0]    set_port,
    input  logic                 clr_stb,
    input  logic [SLOT_W-1:0]    clr_slot,
    input  logic [PORT_W-1:0]    clr_port,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic                 irq
);

    irq_req_t                        set_req;
    irq_req_t                        clr_req;
    logic [NUM_BANKS-1:0][REG_W-1:0] set_hit;
    logic [NUM_BANKS-1:0][REG_W-1:0] clr_hit;
    logic [NUM_BANKS-1:0][REG_W-1:0] sts_q;
    logic [NUM_BANKS-1:0][REG_W-1:0] sts_next;
    logic [NUM_BANKS-1:0][REG_W-1:0] msk_q;
    logic [NUM_BANKS-1:0][REG_W-1:0] msk_next;
    logic [NUM_BANKS-1:0]            bank_pend;
    logic                            irq_q;

    assign set_req = '{stb: set_stb, slot: set_slot, port: set_port};
    assign clr_req = '{stb: clr_stb, slot: clr_slot, port: clr_port};

    netirq_req_decode u_set_dec (
        .clk (clk), .rst (rst), .req (set_req), .hit (set_hit)
    );

    netirq_req_decode u_clr_dec (
        .clk (clk), .rst (rst), .req (clr_req), .hit (clr_hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        netirq_status_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .set_hit  (set_hit[b]),
            .clr_hit  (clr_hit[b]),
            .sts_q    (sts_q[b]),
            .sts_next (sts_next[b])
        );
        assign bank_pend[b] = |(sts_next[b] & msk_next[b]);
    end

    netirq_regbus u_regbus (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .sts_q     (sts_q),
        .msk_q     (msk_q),
        .msk_next  (msk_next),
        .bus_rdata (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |bank_pend;
    end

    assign irq = irq_q;

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq == |((sts_q[0] & msk_q[0]) | (sts_q[1] & msk_q[1])));

    // R2
    bankb_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sts_q[1][LANE_W-1:0] == '0);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sts_q == '0 && msk_q == '0 && !irq));

endmodule

// File: tb/netirq_aggregator_bench.sv
module netirq_aggregator_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_stb = 1'b0, clr_stb = 1'b0, bus_wr = 1'b0;
    logic [2:0]  set_slot = '0, clr_slot = '0;
    logic [3:0]  set_port = '0, clr_port = '0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl_a = '0, mdl_b = '0;
    logic [31:0] mdl_ma = '0, mdl_mb = '0;

    always #10 clk = ~clk;

    netirq_aggregator u_netirq_aggregator (
        .clk(clk), .rst(rst),
        .set_stb(set_stb), .set_slot(set_slot), .set_port(set_port),
        .clr_stb(clr_stb), .clr_slot(clr_slot), .clr_port(clr_port),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // Expected lane placement from R1/R2: bank, base bit; bank -1 means illegal.
    function automatic int lane_bank(input int s);
        case (s)
            0, 1, 3, 4: return 0;
            2, 5, 6:    return 1;
            default:    return -1;
        endcase
    endfunction

    function automatic int lane_base(input int s);
        case (s)
            0: return 0;   1: return 8;  4: return 16; 3: return 24;
            2: return 8;   6: return 16; 5: return 24;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_apply(input int s, input int p, input bit set);
        int bk;
        bk = lane_bank(s);
        if (bk < 0 || p > 7) return;
        if (bk == 0) mdl_a[lane_base(s)+p] = set;
        else         mdl_b[lane_base(s)+p] = set;
    endtask

    task automatic req_set(input int s, input int p);
        set_stb = 1'b1; set_slot = 3'(s); set_port = 4'(p);
        @(negedge clk);
        set_stb = 1'b0;
        model_apply(s, p, 1'b1);
    endtask

    task automatic req_clr(input int s, input int p);
        clr_stb = 1'b1; clr_slot = 3'(s); clr_port = 4'(p);
        @(negedge clk);
        clr_stb = 1'b0;
        model_apply(s, p, 1'b0);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic exp_irq();
        return |((mdl_a & mdl_ma) | (mdl_b & mdl_mb));
    endfunction

    task automatic check_status(input string req);
        logic [31:0] d;
        bus_read(8'h10, d); check(req, d, mdl_a);
        bus_read(8'h18, d); check(req, d, mdl_b);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        check("R9 irq", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 64; a++) begin
            bus_read(8'(a), d);
            check("R9/R8 read", d, 32'h0);
        end

        // R1 R2 R3 R4: sweep all slot/port codes with masks zero
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 16; p++) begin
                req_set(s, p);
                check_status((s > 6 || p > 7) ? "R4 set ignored" :
                             (lane_bank(s) == 0 ? "R1 set" : "R2 set"));
                check("R6 masked irq", {31'b0, irq}, 32'h0);
            end
        end
        check("R2 bank B low byte", mdl_b & 32'hFF, 32'h0);

        // R7 byte aliases and ignored writes
        for (int k = 0; k < 4; k++) begin
            bus_read(8'h10 + 8'(k), d); check("R7 alias A", d, mdl_a);
            bus_read(8'h18 + 8'(k), d); check("R7 alias B", d, mdl_b);
        end
        bus_write(8'h12, 32'h0); #1; check_status("R7 write ignored");
        bus_write(8'h1B, 32'h0); #1; check_status("R7 write ignored");

        // R8 masks: readback, exact-address decode
        bus_write(8'h21, 32'hFFFF_FFFF); bus_write(8'h29, 32'hFFFF_FFFF);
        bus_read(8'h20, d); check("R8 off-address mask A", d, 32'h0);
        bus_read(8'h28, d); check("R8 off-address mask B", d, 32'h0);
        check("R8 off-address irq", {31'b0, irq}, 32'h0);
        bus_write(8'h20, 32'hA5A5_0F0F); mdl_ma = 32'hA5A5_0F0F;
        bus_write(8'h28, 32'h5A5A_F0F0); mdl_mb = 32'h5A5A_F0F0;
        bus_read(8'h20, d); check("R8 mask A", d, mdl_ma);
        bus_read(8'h28, d); check("R8 mask B", d, mdl_mb);
        check("R6 irq mask write", {31'b0, irq}, {31'b0, exp_irq()});

        // R3 R6 clear sweep with full masks
        bus_write(8'h20, 32'hFFFF_FFFF); mdl_ma = '1;
        bus_write(8'h28, 32'hFFFF_FFFF); mdl_mb = '1;
        check("R6 irq full mask", {31'b0, irq}, {31'b0, exp_irq()});
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 16; p++) begin
                req_clr(s, p);
                check_status((s > 6 || p > 7) ? "R4 clr ignored" : "R3 clr");
                check("R6 irq clear", {31'b0, irq}, {31'b0, exp_irq()});
            end
        end
        check("R6 irq all clear", {31'b0, irq}, 32'h0);

        // R6 single-bit mask selectivity: slot 5 port 3 is bank B bit 27
        req_set(5, 3);
        check("R6 irq single", {31'b0, irq}, 32'h1);
        bus_write(8'h28, ~(32'h1 << 27)); mdl_mb = ~(32'h1 << 27);
        check("R6 irq masked off", {31'b0, irq}, 32'h0);
        bus_write(8'h28, 32'h1 << 27); mdl_mb = 32'h1 << 27;
        check("R6 irq masked on", {31'b0, irq}, 32'h1);

        // R5 same bit: set wins
        set_stb = 1'b1; set_slot = 3'd4; set_port = 4'd6;
        clr_stb = 1'b1; clr_slot = 3'd4; clr_port = 4'd6;
        @(negedge clk);
        set_stb = 1'b0; clr_stb = 1'b0;
        model_apply(4, 6, 1'b1);
        check_status("R5 set wins");
        // R5 distinct bits: both apply
        set_stb = 1'b1; set_slot = 3'd0; set_port = 4'd1;
        clr_stb = 1'b1; clr_slot = 3'd5; clr_port = 4'd3;
        @(negedge clk);
        set_stb = 1'b0; clr_stb = 1'b0;
        model_apply(0, 1, 1'b1); model_apply(5, 3, 1'b0);
        check_status("R5 distinct");
        check("R6 irq after clear", {31'b0, irq}, {31'b0, exp_irq()});

        // R9 reset mid-run
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        mdl_a = '0; mdl_b = '0; mdl_ma = '0; mdl_mb = '0;
        check_status("R9 status after reset");
        bus_read(8'h20, d); check("R9 mask A", d, 32'h0);
        check("R9 irq", {31'b0, irq}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule